// File: doc/BRIEF.md
# Dual-Compare Output Compare and PWM Channel

This block is one output compare channel. It watches the count of one of two free-running 16-bit timers, chosen by a select bit, and drives a single output pin. A 3-bit mode field chooses the waveform. The available modes are a one-shot edge on a match, a toggle on each match, a pulse set by one compare register and cleared by a second, and simple PWM whose duty is double-buffered. An interrupt flag pulses on each compare or PWM event.

Software writes three registers over a simple write-only register bus: a control word, a primary compare value and a secondary compare value. In the PWM modes the secondary register holds the next duty value. The channel copies it into the primary register at every period match, so a duty change takes effect only at a period boundary. In the last PWM mode, a fault input shuts the output off. The fault stays latched until software writes the control word again. A hold input freezes the channel while the rest of the system sleeps.

The reset input is asynchronous and active low. The block releases it synchronously through two flops inside the block.

Top module: `ocpwm_channel`

## Requirements
- R1: After reset, pin_o, oe_o and irq_o are 0 and the mode is 000 (off).
- R2: Control bit 3 selects the timer source. With 0, tmr_a_i and per_a_i are used. With 1, tmr_b_i and per_b_i are used. The unselected timer has no effect.
- R3: A bus write to address 0 loads the mode from data bits [2:0] and the timer select from bit 3. Address 1 loads the primary register and address 2 loads the secondary register. A write lands at the clock edge where wr_en_i is high. A control write sets the pin to 1 when the new mode is 010 and to 0 otherwise. It also clears any latched fault and the one-shot state.
- R4: In modes 001 and 010, the first cycle in which the count equals the primary register drives the pin to 1 (mode 001) or 0 (mode 010) at the next edge and pulses irq_o once. Later matches do nothing until the next control write.
- R5: In mode 011, every cycle in which the count equals the primary register inverts the pin and pulses irq_o.
- R6: In modes 100 and 101, a count equal to the primary register sets the pin. A count equal to the secondary register clears the pin and pulses irq_o. When both match in the same cycle, the clear wins.
- R7: Mode 100 produces one pulse and then ignores further matches until the next control write. Mode 101 repeats the pulse on every timer period.
- R8: In modes 110 and 111, a period strobe from the selected timer copies the secondary register into the primary register and pulses irq_o. It also sets the pin to 1, unless the copied value is 0. A count equal to the primary register in any other cycle clears the pin. The strobe takes priority over a bus write to the primary register in the same cycle.
- R9: A duty value of 0 keeps the pin low for the whole period. A duty value equal to or above the period keeps the pin high for the whole period.
- R10: In mode 111, a high fault_i latches a fault. The latched fault forces the pin and oe_o low, pulses irq_o once and blocks all further events until a control write. In mode 110, fault_i is ignored.
- R11: While hold_i is high, the pin, the latched fault, the one-shot state and the primary-register copy are frozen, and irq_o stays 0. Bus writes still land.
- R12: oe_o is 1 exactly when the mode is not 000 and no fault is latched. In mode 000 the pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Freeze the channel (sleep/idle) |
| tmr_a_i | input | 16 | Count of the first timer |
| tmr_b_i | input | 16 | Count of the second timer |
| per_a_i | input | 1 | Period-match strobe of the first timer |
| per_b_i | input | 1 | Period-match strobe of the second timer |
| fault_i | input | 1 | Fault input, active high, used in mode 111 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 primary, 2 secondary |
| wr_data_i | input | 16 | Register write data |
| pin_o | output | 1 | Output pin level |
| oe_o | output | 1 | Output enable |
| irq_o | output | 1 | One-cycle interrupt flag pulse |

## Verification
Three pairs of functions can fall in the same cycle. In the dual-compare modes, both compare registers can match at once. In PWM, the period strobe can coincide with a compare equal to the duty. In mode 111, a fault can arrive in the same cycle as a period strobe. Directed cases provoke each pair. Equal primary and secondary values test the first pair, a duty equal to the period tests the second, and random fault and hold pulses during PWM test the third. A cycle-level bench model scores every cycle by the stated priorities: clear over set, strobe over compare, fault over strobe. Irq pulses are counted over exact three-period windows to separate the one-shot pulse mode from the continuous one.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_HI     = 3'd1,
    M_LO     = 3'd2,
    M_TGL    = 3'd3,
    M_PULSE1 = 3'd4,
    M_PULSEN = 3'd5,
    M_PWM    = 3'd6,
    M_PWMF   = 3'd7
  } oc_mode_e;

  localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRI = 2'd1;
  localparam logic [ADDR_W-1:0] A_SEC = 2'd2;

  localparam int TSEL_BIT = 3;
endpackage

// File: rtl/oc_regfile.sv
module oc_regfile
  import ocpwm_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          dup_load,
  output logic          ctl_wr,
  output oc_mode_e      ctl_new_mode,
  output oc_mode_e      mode_q,
  output logic          tsel_q,
  output logic [W-1:0]  pri_q,
  output logic [W-1:0]  sec_q
);
  oc_mode_e   mode_d;
  logic       tsel_d;
  logic [W-1:0] pri_d, sec_d;
  logic       pri_wr, sec_wr;

  assign ctl_wr       = wr_en && (wr_addr == A_CTL);
  assign pri_wr       = wr_en && (wr_addr == A_PRI);
  assign sec_wr       = wr_en && (wr_addr == A_SEC);
  assign ctl_new_mode = oc_mode_e'(wr_data[2:0]);

  always_comb begin
    mode_d = mode_q;
    tsel_d = tsel_q;
    pri_d  = pri_q;
    sec_d  = sec_q;
    if (ctl_wr) begin
      mode_d = ctl_new_mode;
      tsel_d = wr_data[TSEL_BIT];
    end
    if (dup_load)    pri_d = sec_q;
    else if (pri_wr) pri_d = wr_data;
    if (sec_wr) sec_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      tsel_q <= 1'b0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else begin
      mode_q <= mode_d;
      tsel_q <= tsel_d;
      pri_q  <= pri_d;
      sec_q  <= sec_d;
    end
  end

  // R8: a period copy moves the buffered duty into the primary register
  assert_dup_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dup_load |=> (pri_q == $past(sec_q)));
  // R3: a control write lands in the mode field
  assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (mode_q == $past(ctl_new_mode)));
endmodule

// File: rtl/oc_source.sv
module oc_source
  import ocpwm_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int NSRC = 2
) (
  input  logic                tsel,
  input  logic [NSRC*W-1:0]   tmr_flat,
  input  logic [NSRC-1:0]     per_vec,
  input  logic [W-1:0]        pri,
  input  logic [W-1:0]        sec,
  output logic                hit_pri,
  output logic                hit_sec,
  output logic                per_hit
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [W-1:0] cnt_arr [NSRC];
  logic [W-1:0] cnt;
  logic [SW-1:0] sel;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign cnt_arr[g] = tmr_flat[g*W +: W];
    end
  endgenerate

  assign sel     = SW'(tsel);
  assign cnt     = cnt_arr[sel];
  assign per_hit = per_vec[sel];
  assign hit_pri = (cnt == pri);
  assign hit_sec = (cnt == sec);
endmodule

// File: rtl/oc_outlogic.sv
module oc_outlogic
  import ocpwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold,
  input  logic     fault_in,
  input  oc_mode_e mode_q,
  input  logic     ctl_wr,
  input  oc_mode_e ctl_new_mode,
  input  logic     hit_pri,
  input  logic     hit_sec,
  input  logic     per_hit,
  input  logic     sec_zero,
  output logic     dup_load,
  output logic     pin_q,
  output logic     oe,
  output logic     irq_q
);
  logic pin_d, fault_q, fault_d, done_q, done_d, irq_d;

  always_comb begin
    pin_d    = pin_q;
    fault_d  = fault_q;
    done_d   = done_q;
    irq_d    = 1'b0;
    dup_load = 1'b0;
    if (ctl_wr) begin
      pin_d   = (ctl_new_mode == M_LO);
      fault_d = 1'b0;
      done_d  = 1'b0;
    end else if (!hold) begin
      unique case (mode_q)
        M_OFF: pin_d = 1'b0;
        M_HI, M_LO: begin
          if (hit_pri && !done_q) begin
            pin_d  = (mode_q == M_HI);
            done_d = 1'b1;
            irq_d  = 1'b1;
          end
        end
        M_TGL: begin
          if (hit_pri) begin
            pin_d = ~pin_q;
            irq_d = 1'b1;
          end
        end
        M_PULSE1, M_PULSEN: begin
          if (!done_q) begin
            if (hit_sec) begin
              pin_d  = 1'b0;
              irq_d  = 1'b1;
              done_d = (mode_q == M_PULSE1);
            end else if (hit_pri) begin
              pin_d = 1'b1;
            end
          end
        end
        default: begin
          if (fault_q) begin
            pin_d = 1'b0;
          end else if ((mode_q == M_PWMF) && fault_in) begin
            fault_d = 1'b1;
            pin_d   = 1'b0;
            irq_d   = 1'b1;
          end else if (per_hit) begin
            dup_load = 1'b1;
            pin_d    = !sec_zero;
            irq_d    = 1'b1;
          end else if (hit_pri) begin
            pin_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pin_q   <= pin_d;
      fault_q <= fault_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  assign oe = (mode_q != M_OFF) && !fault_q;

  // R12: off mode keeps the pin low
  assert_off_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF && !ctl_wr) |=> !pin_q);
  // R11: hold freezes pin and fault latch
  assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ctl_wr) |=> ($stable(pin_q) && $stable(fault_q) && !irq_q));
  // R10: a latched fault persists until a control write
  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !ctl_wr) |=> fault_q);
  // R10: while faulted the pin is low
  assert_fault_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !ctl_wr) |=> !pin_q);
  // R8: a period strobe with nonzero duty raises the pin
  assert_pwm_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !hold && !fault_q && !fault_in && mode_q == M_PWM && per_hit && !sec_zero) |=> pin_q);
endmodule

// File: rtl/ocpwm_channel.sv
module ocpwm_channel
  import ocpwm_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic [W-1:0]  tmr_a_i,
  input  logic [W-1:0]  tmr_b_i,
  input  logic          per_a_i,
  input  logic          per_b_i,
  input  logic          fault_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          pin_o,
  output logic          oe_o,
  output logic          irq_o
);
  localparam int NSRC = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic     ctl_wr, tsel_q, dup_load, hit_pri, hit_sec, per_hit;
  oc_mode_e ctl_new_mode, mode_q;
  logic [W-1:0] pri_q, sec_q;

  oc_regfile #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .dup_load(dup_load),
    .ctl_wr(ctl_wr), .ctl_new_mode(ctl_new_mode),
    .mode_q(mode_q), .tsel_q(tsel_q), .pri_q(pri_q), .sec_q(sec_q)
  );

  oc_source #(.W(W), .NSRC(NSRC)) u_src (
    .tsel(tsel_q),
    .tmr_flat({tmr_b_i, tmr_a_i}),
    .per_vec({per_b_i, per_a_i}),
    .pri(pri_q), .sec(sec_q),
    .hit_pri(hit_pri), .hit_sec(hit_sec), .per_hit(per_hit)
  );

  oc_outlogic u_out (
    .clk(clk), .rst_n(rst_ns),
    .hold(hold_i), .fault_in(fault_i),
    .mode_q(mode_q), .ctl_wr(ctl_wr), .ctl_new_mode(ctl_new_mode),
    .hit_pri(hit_pri), .hit_sec(hit_sec), .per_hit(per_hit),
    .sec_zero(sec_q == '0),
    .dup_load(dup_load),
    .pin_q(pin_o), .oe(oe_o), .irq_q(irq_o)
  );
endmodule

// File: tb/ocpwm_channel_test.sv
`timescale 1ns/1ps
module ocpwm_channel_test;
  localparam int PRA = 19;
  localparam int PRB = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_i = 1'b0, fault_i = 1'b0, wr_en_i = 1'b0;
  logic [15:0] tmr_a_i = '0, tmr_b_i = '0, wr_data_i = '0;
  logic per_a_i = 1'b0, per_b_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic pin_o, oe_o, irq_o;

  int tests = 0, fails = 0;
  bit finished = 0;
  bit live = 0;

  always #2 clk = ~clk;

  ocpwm_channel uut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
    .tmr_a_i(tmr_a_i), .tmr_b_i(tmr_b_i), .per_a_i(per_a_i), .per_b_i(per_b_i),
    .fault_i(fault_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pin_o(pin_o), .oe_o(oe_o), .irq_o(irq_o)
  );

  // Cycle-level expectation model built from the requirement text
  logic [2:0]  m_mode;
  logic        m_tsel, m_pin, m_fault, m_done, m_irq, m_prev_hold;
  logic [15:0] m_pri, m_sec;

  function automatic string tag_of(input logic [2:0] md, input logic hd);
    if (hd) return "R11";
    case (md)
      3'd0: return "R12";
      3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3'd0; m_tsel = 0; m_pin = 0; m_fault = 0; m_done = 0; m_irq = 0;
      m_pri = '0; m_sec = '0; m_prev_hold = 0;
    end else begin
      logic [15:0] c;
      logic hp, hs, pe, ld;
      c  = m_tsel ? tmr_b_i : tmr_a_i;
      pe = m_tsel ? per_b_i : per_a_i;
      hp = (c == m_pri);
      hs = (c == m_sec);
      ld = 0;
      m_irq = 0;
      m_prev_hold = hold_i;
      if (wr_en_i && wr_addr_i == 2'd0) begin
        m_pin = (wr_data_i[2:0] == 3'd2); m_fault = 0; m_done = 0;
      end else if (!hold_i) begin
        if (m_mode == 3'd0) m_pin = 0;
        else if (m_mode == 3'd1 || m_mode == 3'd2) begin
          if (hp && !m_done) begin m_pin = (m_mode == 3'd1); m_done = 1; m_irq = 1; end
        end else if (m_mode == 3'd3) begin
          if (hp) begin m_pin = !m_pin; m_irq = 1; end
        end else if (m_mode == 3'd4 || m_mode == 3'd5) begin
          if (!m_done && hs) begin m_pin = 0; m_irq = 1; m_done = (m_mode == 3'd4); end
          else if (!m_done && hp) m_pin = 1;
        end else begin
          if (m_fault) m_pin = 0;
          else if (m_mode == 3'd7 && fault_i) begin m_fault = 1; m_pin = 0; m_irq = 1; end
          else if (pe) begin ld = 1; m_pin = (m_sec != 0); m_irq = 1; end
          else if (hp) m_pin = 0;
        end
      end
      if (ld) m_pri = m_sec;
      else if (wr_en_i && wr_addr_i == 2'd1) m_pri = wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd2) m_sec = wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd0) begin m_mode = wr_data_i[2:0]; m_tsel = wr_data_i[3]; end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (live) begin
      string t;
      t = tag_of(m_mode, m_prev_hold);
      chk(t, "pin", pin_o, m_pin);
      chk(m_fault ? "R10" : "R12", "oe", oe_o, (m_mode != 0) && !m_fault);
      chk(t, "irq", irq_o, m_irq);
    end
    tmr_a_i = (tmr_a_i == PRA) ? 16'd0 : tmr_a_i + 16'd1;
    tmr_b_i = (tmr_b_i == PRB) ? 16'd0 : tmr_b_i + 16'd1;
    per_a_i = (tmr_a_i == PRA);
    per_b_i = (tmr_b_i == PRB);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic count_win(input int n, output int highs, output int irqs);
    highs = 0; irqs = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      highs += pin_o; irqs += irq_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int h, q, seed;
    seed = $urandom(32'h5eed_0c11);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pin", pin_o, 0); chk("R1", "oe", oe_o, 0); chk("R1", "irq", irq_o, 0);
    rst_n = 1;
    run(4);
    chk("R1", "pin after release", pin_o, 0);
    chk("R1", "oe after release", oe_o, 0);
    live = 1;

    // R2: primary 15 is reachable only by timer A (period 19), not timer B (11)
    wr(2'd1, 16'd15);
    wr(2'd0, 16'h0009);
    count_win(3 * (PRB + 1), h, q);
    chk("R2", "timer B never reaches 15", h, 0);
    wr(2'd0, 16'h0001);
    count_win(PRA + 1, h, q);
    chk("R2", "timer A reaches 15 once", q, 1);

    // R3: control write to mode 010 raises the pin, enables output
    wr(2'd1, 16'd200);
    wr(2'd0, 16'h0002);
    chk("R3", "pin preset for 010", pin_o, 1);
    chk("R3", "oe after control write", oe_o, 1);

    // R6 with equal compares: clear wins, pin never high
    wr(2'd1, 16'd7); wr(2'd2, 16'd7);
    wr(2'd0, 16'h0005);
    count_win(3 * (PRA + 1), h, q);
    chk("R6", "equal compares keep pin low", h, 0);
    chk("R6", "equal compares irq count", q, 3);

    // R7: single pulse vs continuous
    wr(2'd1, 16'd3); wr(2'd2, 16'd8);
    wr(2'd0, 16'h0004);
    count_win(3 * (PRA + 1), h, q);
    chk("R7", "single pulse irq count", q, 1);
    chk("R7", "single pulse width", h, 5);
    wr(2'd0, 16'h0005);
    count_win(3 * (PRA + 1), h, q);
    chk("R7", "continuous irq count", q, 3);
    chk("R7", "continuous width", h, 15);

    // R9: duty 0 keeps pin low
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0006);
    count_win(3 * (PRA + 1), h, q);
    chk("R9", "duty 0 high cycles", h, 0);
    chk("R8", "period irq count", q, 3);
    // R9: duty above period keeps pin high after first strobe
    wr(2'd2, 16'd25);
    run(PRA + 2);
    count_win(2 * (PRA + 1), h, q);
    chk("R9", "duty over period high cycles", h, 2 * (PRA + 1));
    // duty equal to period: strobe wins over compare
    wr(2'd2, PRA);
    run(PRA + 2);
    count_win(2 * (PRA + 1), h, q);
    chk("R9", "duty equal period high cycles", h, 2 * (PRA + 1));
    // R8: duty 6 gives 7 high cycles per period (counts 0..6)
    wr(2'd2, 16'd6);
    run(PRA + 2);
    count_win(PRA + 1, h, q);
    chk("R8", "duty 6 high cycles", h, 7);

    // R10: fault latches in 111
    wr(2'd2, 16'd10);
    wr(2'd0, 16'h0007);
    run(25);
    fault_i = 1; tick(); fault_i = 0;
    chk("R10", "irq on fault", irq_o, 1);
    count_win(2 * (PRA + 1), h, q);
    chk("R10", "pin low while faulted", h, 0);
    chk("R10", "no events while faulted", q, 0);
    chk("R10", "oe low while faulted", oe_o, 0);
    wr(2'd0, 16'h0007);
    chk("R10", "oe back after control write", oe_o, 1);
    // mode 110 ignores fault
    wr(2'd0, 16'h0006);
    run(25);
    fault_i = 1; run(3); fault_i = 0;
    chk("R10", "110 oe unaffected by fault", oe_o, 1);

    // R11: hold freezes a toggling output
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h0003);
    run(10);
    h = pin_o;
    hold_i = 1;
    count_win(3 * (PRA + 1), q, seed);
    hold_i = 0;
    chk("R11", "pin frozen under hold", pin_o, h);
    chk("R11", "no irq under hold", seed, 0);

    // Random phase: model compares every cycle
    for (int r = 0; r < 60; r++) begin
      logic [2:0] md;
      logic ts;
      int pr;
      md = 3'($urandom_range(0, 7));
      ts = 1'($urandom_range(0, 1));
      pr = ts ? PRB : PRA;
      wr(2'd1, 16'($urandom_range(0, pr + 2)));
      wr(2'd2, 16'($urandom_range(0, pr + 2)));
      wr(2'd0, {12'd0, ts, md});
      for (int i = 0; i < 80; i++) begin
        hold_i  = ($urandom_range(0, 15) == 0);
        fault_i = ($urandom_range(0, 59) == 0);
        if (md[2:1] == 2'b11 && $urandom_range(0, 29) == 0) begin
          wr_en_i = 1; wr_addr_i = 2'($urandom_range(1, 2));
          wr_data_i = 16'($urandom_range(0, pr + 2));
        end
        tick();
        wr_en_i = 0;
      end
      hold_i = 0; fault_i = 0;
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule